// File: doc/BRIEF.md
# SPI Serial EEPROM Command Front End

This block is the slave-side serial engine of a 512-byte serial EEPROM that uses 9-bit addresses. It watches the chip-select, serial clock and serial data-in lines in SPI mode 0. It decodes each 8-bit instruction and collects the address. It serves array reads and status reads on the serial data-out line. Write traffic goes to a separate write controller. The controller receives one pulse per received data byte and a commit pulse at the end of a valid transaction.

The array storage, write protection, write-enable bookkeeping and write timing all sit outside this block. The block learns what it needs through two inputs. The status byte input carries the in-progress flag in bit 0. The write-permit input tells the block whether a write or status-write instruction may proceed.

All serial inputs are sampled by the block's own system clock. They are treated as synchronous to it, and each serial clock phase is assumed to last several system clocks. Serial clock edges are found by comparing each sample with the previous one. The output enable and the data-out bit are meant to drive an external three-state pad.

Top module: `spi_ee_front`

## Requirements
- R1: Instruction bytes are decoded as follows, where A is address bit 8: read = 0000_A011, write = 0000_A010, status read = 0000_0101, write enable = 0000_0110, status write = 0000_0001. A read or write instruction is followed by one byte holding address bits 7..0, most significant bit first.
- R2: After the address byte of a read, the byte at that address appears on `spi_so`, most significant bit first. The first bit is valid after the serial clock falling edge that follows the last address bit. Data-in activity during the data phase has no effect on the output.
- R3: While chip select stays low, a read keeps streaming consecutive addresses. After address 0x1FF it continues at 0x000.
- R4: A status read returns `stat_byte`, most significant bit first. The value is taken again at the start of each byte for as long as chip select stays low.
- R5: While `stat_byte[0]` is 1, every instruction other than status read is ignored until the next chip-select falling edge. Such an instruction drives no output and produces no write pulse.
- R6: Each complete data byte of a write produces a one-cycle `wr_byte_vld` with `wr_addr` and `wr_data`. After each byte, only the low three address bits advance, and they wrap inside the 8-byte page. The upper six bits stay fixed.
- R7: When chip select rises on a byte boundary, `wr_commit` pulses for one cycle with `wr_op` set. The code is 2 after a write or 3 after a status write that delivered at least one data byte, and 1 after a write-enable instruction. A rise in the middle of a byte gives no commit.
- R8: A write or status-write instruction received while `wr_allow` is 0 is ignored until the next chip-select falling edge. It gives no byte pulse and no commit.
- R9: `spi_so_oe` is 0 while chip select is high and before the first output bit of a transaction. `spi_so` changes only after a serial clock falling edge.
- R10: A chip-select rise resets the bit counter and command state in any phase. The next transaction starts with a fresh instruction byte.
- R11: An instruction byte that matches no encoding in R1 causes the rest of the transaction to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for the data-out pad |
| mem_rd_addr | output | 9 | Array read address |
| mem_rd_data | input | 8 | Array read data, combinational from the address |
| stat_byte | input | 8 | Status byte; bit 0 means a write cycle is in progress |
| wr_allow | input | 1 | Write and status-write instructions are permitted |
| wr_byte_vld | output | 1 | One-cycle pulse per received data byte |
| wr_addr | output | 9 | Address of the delivered byte |
| wr_data | output | 8 | Delivered data byte |
| wr_commit | output | 1 | One-cycle pulse ending a valid transaction |
| wr_op | output | 2 | Kind of the committed transaction: 1 enable, 2 write, 3 status write |

## Verification
A serial clock edge is seen at the first system clock edge after it arrives. An output bit is therefore present one system clock after the falling edge. The bench holds each serial clock phase for four system clocks and samples `spi_so` and `spi_so_oe` just before it raises the serial clock, well after the output has settled. The byte and commit pulses appear one clock after the rising edge that completes a byte, or after the chip-select rise. They last a single cycle, so a monitor on the falling system clock edge logs every one of them, and the bench compares those logs after chip select has gone high again.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + 1;

  localparam logic [BYTE_W-1:0] OPC_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_WRSR = 8'h01;
  localparam logic [2:0]        LOW_READ = 3'b011;
  localparam logic [2:0]        LOW_WRIT = 3'b010;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_RDAT, ST_STAT, ST_WDAT, ST_SDAT, ST_WEN, ST_IGN
  } st_e;

  typedef enum logic [1:0] {
    WOP_NONE = 2'd0, WOP_WREN = 2'd1, WOP_WRITE = 2'd2, WOP_WRSR = 2'd3
  } wop_e;
endpackage

// File: rtl/spi_ee_edge.sv
module spi_ee_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = !cs_n &&  sck && !sck_q;
  assign sck_fall = !cs_n && !sck &&  sck_q;
  assign cs_rise  =  cs_n && !cs_q;
endmodule

// File: rtl/spi_ee_fsm.sv
module spi_ee_fsm
  import spi_ee_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              si,
  input  logic              busy,
  input  logic              wr_allow,
  output st_e               st_o,
  output logic [2:0]        bit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_byte_vld,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit,
  output wop_e              wr_op
);
  st_e               st_q, st_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic              a8_q, a8_d, rd_q, rd_d, have_q, have_d;
  logic [ADDR_W-1:0] addr_q, addr_d, waddr_q, waddr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d, byte_in;
  logic              wvld_q, wvld_d, wcom_q, wcom_d;
  wop_e              wop_q, wop_d;
  logic              byte_done;

  assign byte_in   = {sh_q, si};
  assign byte_done = sck_rise && (bit_q == 3'd7);

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    a8_d    = a8_q;
    rd_d    = rd_q;
    have_d  = have_q;
    addr_d  = addr_q;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    wvld_d  = 1'b0;
    wcom_d  = 1'b0;
    wop_d   = wop_q;
    if (cs_n) begin
      st_d   = ST_OPC;
      bit_d  = 3'd0;
      sh_d   = '0;
      have_d = 1'b0;
      if (cs_rise && bit_q == 3'd0) begin
        if (st_q == ST_WDAT && have_q) begin
          wcom_d = 1'b1;
          wop_d  = WOP_WRITE;
        end else if (st_q == ST_SDAT && have_q) begin
          wcom_d = 1'b1;
          wop_d  = WOP_WRSR;
        end else if (st_q == ST_WEN) begin
          wcom_d = 1'b1;
          wop_d  = WOP_WREN;
        end
      end
    end else if (sck_rise) begin
      bit_d = bit_q + 3'd1;
      sh_d  = byte_in[BYTE_W-2:0];
      if (byte_done) begin
        unique case (st_q)
          ST_OPC: begin
            if (busy && byte_in != OPC_RDSR) begin
              st_d = ST_IGN;
            end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == LOW_READ) begin
              st_d = ST_ADDR;
              a8_d = byte_in[3];
              rd_d = 1'b1;
            end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == LOW_WRIT) begin
              st_d = wr_allow ? ST_ADDR : ST_IGN;
              a8_d = byte_in[3];
              rd_d = 1'b0;
            end else if (byte_in == OPC_RDSR) begin
              st_d = ST_STAT;
            end else if (byte_in == OPC_WREN) begin
              st_d = ST_WEN;
            end else if (byte_in == OPC_WRSR) begin
              st_d = wr_allow ? ST_SDAT : ST_IGN;
            end else begin
              st_d = ST_IGN;
            end
          end
          ST_ADDR: begin
            addr_d = {a8_q, byte_in};
            st_d   = rd_q ? ST_RDAT : ST_WDAT;
          end
          ST_RDAT: addr_d = addr_q + 1'b1;
          ST_WDAT: begin
            wvld_d  = 1'b1;
            waddr_d = addr_q;
            wdata_d = byte_in;
            have_d  = 1'b1;
            addr_d  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
          end
          ST_SDAT: begin
            if (!have_q) begin
              wvld_d  = 1'b1;
              waddr_d = '0;
              wdata_d = byte_in;
              have_d  = 1'b1;
            end
          end
          default: st_d = st_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OPC;
      bit_q   <= 3'd0;
      sh_q    <= '0;
      a8_q    <= 1'b0;
      rd_q    <= 1'b0;
      have_q  <= 1'b0;
      addr_q  <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      wvld_q  <= 1'b0;
      wcom_q  <= 1'b0;
      wop_q   <= WOP_NONE;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      a8_q    <= a8_d;
      rd_q    <= rd_d;
      have_q  <= have_d;
      addr_q  <= addr_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      wvld_q  <= wvld_d;
      wcom_q  <= wcom_d;
      wop_q   <= wop_d;
    end
  end

  assign st_o        = st_q;
  assign bit_o       = bit_q;
  assign rd_addr_o   = addr_q;
  assign wr_byte_vld = wvld_q;
  assign wr_addr     = waddr_q;
  assign wr_data     = wdata_q;
  assign wr_commit   = wcom_q;
  assign wr_op       = wop_q;

  // R5: with a write in progress, only the status read may leave the opcode phase
  assert_busy_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(st_q) == ST_OPC && !$past(cs_n)) |->
      (st_q == ST_OPC || st_q == ST_STAT || st_q == ST_IGN));

  // R6: page write keeps the upper address bits fixed
  assert_page_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WDAT && $past(st_q) == ST_WDAT) |->
      $stable(addr_q[ADDR_W-1:PAGE_W]));

  // R7: a commit only follows a chip-select rise on a byte boundary
  assert_commit_on_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> ($past(cs_n) && $past(bit_q) == 3'd0));

  // R10: chip select high clears the bit counter
  assert_cs_resets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (bit_q == 3'd0 && st_q == ST_OPC));
endmodule

// File: rtl/spi_ee_sout.sv
module spi_ee_sout
  import spi_ee_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_fall,
  input  st_e               st,
  input  logic [2:0]        bit_cnt,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] stat_byte,
  output logic              so,
  output logic              so_oe
);
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              oe_q, oe_d;
  logic              talk;

  assign talk = (st == ST_RDAT) || (st == ST_STAT);

  always_comb begin
    sr_d = sr_q;
    oe_d = oe_q;
    if (cs_n) begin
      sr_d = '0;
      oe_d = 1'b0;
    end else if (sck_fall && talk) begin
      oe_d = 1'b1;
      if (bit_cnt == 3'd0) sr_d = (st == ST_RDAT) ? rd_data : stat_byte;
      else                 sr_d = {sr_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      oe_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      oe_q <= oe_d;
    end
  end

  assign so    = sr_q[BYTE_W-1];
  assign so_oe = oe_q;

  // R9: output released whenever chip select is high
  assert_oe_off_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_oe);

  // R9: driven output only moves after a serial clock falling edge
  assert_so_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));
endmodule

// File: rtl/spi_ee_front.sv
module spi_ee_front
  import spi_ee_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_cs_n,
  input  logic                  spi_sck,
  input  logic                  spi_si,
  output logic                  spi_so,
  output logic                  spi_so_oe,
  output logic [ADDR_W-1:0]     mem_rd_addr,
  input  logic [BYTE_W-1:0]     mem_rd_data,
  input  logic [BYTE_W-1:0]     stat_byte,
  input  logic                  wr_allow,
  output logic                  wr_byte_vld,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [BYTE_W-1:0]     wr_data,
  output logic                  wr_commit,
  output logic [1:0]            wr_op
);
  logic [1:0] rst_pipe;
  logic       rst_s;
  logic       sck_rise, sck_fall, cs_rise;
  st_e        st;
  logic [2:0] bit_cnt;
  wop_e       op_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  spi_ee_edge u_edge (
    .clk(clk), .rst_n(rst_s), .sck(spi_sck), .cs_n(spi_cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
  );

  spi_ee_fsm #(.PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_s), .cs_n(spi_cs_n), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .si(spi_si), .busy(stat_byte[0]), .wr_allow(wr_allow),
    .st_o(st), .bit_o(bit_cnt), .rd_addr_o(mem_rd_addr),
    .wr_byte_vld(wr_byte_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_op(op_e)
  );

  spi_ee_sout u_sout (
    .clk(clk), .rst_n(rst_s), .cs_n(spi_cs_n), .sck_fall(sck_fall),
    .st(st), .bit_cnt(bit_cnt), .rd_data(mem_rd_data), .stat_byte(stat_byte),
    .so(spi_so), .so_oe(spi_so_oe)
  );

  assign wr_op = op_e;

  // R6/R7: a byte delivery and a commit never share a cycle
  assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_s)
    !(wr_byte_vld && wr_commit));
endmodule

// File: tb/sim_spi_ee_front.sv
module sim_spi_ee_front;
  localparam int HALF = 4;

  logic       clk, rst_n;
  logic       spi_cs_n, spi_sck, spi_si;
  logic       spi_so, spi_so_oe;
  logic [8:0] mem_rd_addr;
  logic [7:0] mem_rd_data, stat_byte;
  logic       wr_allow;
  logic       wr_byte_vld, wr_commit;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] wr_op;

  int n_cmp = 0;
  int n_bad = 0;

  logic [8:0] mon_addr [64];
  logic [7:0] mon_data [64];
  int         mon_n, com_n;
  logic [1:0] com_op;

  function automatic logic [7:0] memf(input logic [8:0] a);
    return (a[7:0] * 8'd37) ^ {a[8], a[8:2]} ^ 8'h5A;
  endfunction

  assign mem_rd_data = memf(mem_rd_addr);

  spi_ee_front u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .stat_byte(stat_byte),
    .wr_allow(wr_allow), .wr_byte_vld(wr_byte_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .wr_op(wr_op)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && wr_byte_vld) begin
      if (mon_n < 64) begin
        mon_addr[mon_n] = wr_addr;
        mon_data[mon_n] = wr_data;
      end
      mon_n = mon_n + 1;
    end
    if (rst_n && wr_commit) begin
      com_n  = com_n + 1;
      com_op = wr_op;
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mon_clear;
    mon_n  = 0;
    com_n  = 0;
    com_op = 2'd0;
  endtask

  task automatic cs_begin;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb,
                      output logic [7:0] rx, output logic oe_any);
    rx = '0;
    oe_any = 1'b0;
    for (int i = 7; i >= 8 - nb; i--) begin
      spi_si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i]  = spi_so;
      oe_any = oe_any | spi_so_oe;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic do_read(input logic [8:0] a, input int len, input string req);
    logic [7:0] rx;
    logic oe;
    cs_begin();
    xfer({4'h0, a[8], 3'b011}, 8, rx, oe);
    xfer(a[7:0], 8, rx, oe);
    chk("R9 oe before data", {31'd0, oe}, 32'd0);
    for (int k = 0; k < len; k++) begin
      xfer(8'($urandom), 8, rx, oe);
      chk(req, {24'd0, rx}, {24'd0, memf(9'(a + 9'(k)))});
      chk("R2 oe during data", {31'd0, oe}, 32'd1);
    end
    cs_end();
    chk("R9 oe after cs high", {31'd0, spi_so_oe}, 32'd0);
  endtask

  task automatic do_write(input logic [8:0] a, input int n, input logic [7:0] d0);
    logic [7:0] rx;
    logic oe;
    mon_clear();
    cs_begin();
    xfer({4'h0, a[8], 3'b010}, 8, rx, oe);
    xfer(a[7:0], 8, rx, oe);
    for (int k = 0; k < n; k++) xfer(8'(d0 + 8'(k * 13)), 8, rx, oe);
    cs_end();
    chk("R6 byte count", mon_n, n);
    for (int k = 0; k < n && k < 64; k++) begin
      chk("R6 page addr", {23'd0, mon_addr[k]}, {23'd0, a[8:3], 3'(a[2:0] + 3'(k))});
      chk("R6 data", {24'd0, mon_data[k]}, {24'd0, 8'(d0 + 8'(k * 13))});
    end
    chk("R7 commit count", com_n, 1);
    chk("R7 commit op write", {30'd0, com_op}, 32'd2);
  endtask

  initial begin
    logic [7:0] rx;
    logic oe;
    logic [7:0] sb;
    void'($urandom(32'd4242));
    rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = 1'b0; spi_si = 1'b0;
    stat_byte = 8'h00; wr_allow = 1'b0;
    mon_clear();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R9 reset oe", {31'd0, spi_so_oe}, 32'd0);
    chk("R7 reset commit", {31'd0, wr_commit}, 32'd0);
    chk("R6 reset byte pulse", {31'd0, wr_byte_vld}, 32'd0);

    // R1 R2 R3: random reads
    for (int t = 0; t < 16; t++)
      do_read(9'($urandom), 1 + int'($urandom % 5), "R2 R3 read data");
    // R3: wrap at top of array; R1: A8 from opcode
    do_read(9'h1FD, 5, "R3 wrap");
    do_read(9'h100, 2, "R1 A8 high");
    do_read(9'h0FF, 2, "R1 A8 low carry");

    // R4: status read, repeated bytes
    for (int t = 0; t < 3; t++) begin
      sb = {7'($urandom), 1'b0};
      stat_byte = sb;
      cs_begin();
      xfer(8'h05, 8, rx, oe);
      chk("R9 oe during opcode", {31'd0, oe}, 32'd0);
      xfer(8'h00, 8, rx, oe);
      chk("R4 status byte", {24'd0, rx}, {24'd0, sb});
      sb = {7'($urandom), 1'b0};
      stat_byte = sb;
      xfer(8'h00, 8, rx, oe);
      chk("R4 status refreshed", {24'd0, rx}, {24'd0, sb});
      cs_end();
    end

    // R5: busy lockout
    stat_byte = 8'hA1;
    wr_allow = 1'b1;
    cs_begin();
    xfer(8'h03, 8, rx, oe);
    xfer(8'h10, 8, rx, oe);
    xfer(8'h00, 8, rx, oe);
    chk("R5 read ignored oe", {31'd0, oe}, 32'd0);
    cs_end();
    mon_clear();
    cs_begin();
    xfer(8'h02, 8, rx, oe);
    xfer(8'h20, 8, rx, oe);
    xfer(8'h77, 8, rx, oe);
    cs_end();
    chk("R5 write ignored bytes", mon_n, 0);
    chk("R5 write ignored commit", com_n, 0);
    mon_clear();
    cs_begin();
    xfer(8'h06, 8, rx, oe);
    cs_end();
    chk("R5 enable ignored", com_n, 0);
    cs_begin();
    xfer(8'h05, 8, rx, oe);
    xfer(8'h00, 8, rx, oe);
    chk("R5 status allowed when busy", {24'd0, rx}, 32'hA1);
    cs_end();
    stat_byte = 8'h00;

    // R6 R7: page writes, including page wrap
    do_write(9'h1F5, 6, 8'h11);
    do_write(9'h03A, 10, 8'hC3);
    for (int t = 0; t < 4; t++)
      do_write(9'($urandom), 1 + int'($urandom % 8), 8'($urandom));

    // R7: chip select rises mid-byte
    mon_clear();
    cs_begin();
    xfer(8'h0A, 8, rx, oe);
    xfer(8'h44, 8, rx, oe);
    xfer(8'h5C, 8, rx, oe);
    xfer(8'hFF, 3, rx, oe);
    cs_end();
    chk("R7 abort byte delivered", mon_n, 1);
    chk("R7 abort no commit", com_n, 0);

    // R7: write with no data byte gives no commit
    mon_clear();
    cs_begin();
    xfer(8'h02, 8, rx, oe);
    xfer(8'h44, 8, rx, oe);
    cs_end();
    chk("R7 no data no commit", com_n, 0);

    // R7: write enable and status write
    mon_clear();
    cs_begin();
    xfer(8'h06, 8, rx, oe);
    cs_end();
    chk("R7 enable commit", com_n, 1);
    chk("R7 enable op", {30'd0, com_op}, 32'd1);
    mon_clear();
    cs_begin();
    xfer(8'h01, 8, rx, oe);
    xfer(8'h8C, 8, rx, oe);
    cs_end();
    chk("R7 wrsr byte", mon_n, 1);
    chk("R7 wrsr data", {24'd0, mon_data[0]}, 32'h8C);
    chk("R7 wrsr commit", com_n, 1);
    chk("R7 wrsr op", {30'd0, com_op}, 32'd3);

    // R8: writes refused without permission
    wr_allow = 1'b0;
    mon_clear();
    cs_begin();
    xfer(8'h0A, 8, rx, oe);
    xfer(8'h12, 8, rx, oe);
    xfer(8'h34, 8, rx, oe);
    cs_end();
    cs_begin();
    xfer(8'h01, 8, rx, oe);
    xfer(8'h34, 8, rx, oe);
    cs_end();
    chk("R8 refused bytes", mon_n, 0);
    chk("R8 refused commit", com_n, 0);
    do_read(9'h012, 1, "R8 read still works");
    wr_allow = 1'b1;

    // R11: unknown opcode ignored
    mon_clear();
    cs_begin();
    xfer(8'hFF, 8, rx, oe);
    xfer(8'h00, 8, rx, oe);
    xfer(8'h00, 8, rx, oe);
    chk("R11 unknown no output", {31'd0, oe}, 32'd0);
    cs_end();
    chk("R11 unknown no commit", com_n, 0);

    // R10: abort mid-opcode, then a clean read
    cs_begin();
    xfer(8'hA5, 4, rx, oe);
    cs_end();
    do_read(9'h155, 2, "R10 fresh after abort");
    cs_begin();
    xfer(8'h0B, 8, rx, oe);
    xfer(8'hC0, 5, rx, oe);
    cs_end();
    do_read(9'h0C0, 1, "R10 fresh after address abort");

    summary();
    $finish;
  end
endmodule